// File: doc/BRIEF.md
# Single-Block DMA Transfer Engine

This block moves a contiguous block of words between memory and one I/O device with no CPU involvement per word. Software loads a start address, a word count and a direction while the engine is idle, then pulses a start input. The engine asks the CPU for the bus, waits for the grant, and then acts as bus master. For each word it waits for the device to be ready, performs one read on the source side and one write on the destination side, then steps the address up by one and the remaining count down by one.

The remaining count is kept in a down counter. The engine hands the bus back in the same cycle that this counter reaches zero. It then raises a sticky done flag and a single-cycle completion pulse. A start issued with a count of zero finishes at once, without touching the bus.

Top module: `dma_blk_ctrl`

## Requirements
- R1: While reset is held and right after it, bus_req_o, every access strobe, done_o and done_pulse_o are 0.
- R2: A start_i sampled in idle with a nonzero count asserts bus_req_o from the next cycle. No access strobe is driven until bus_ack_i has been sampled high while requesting.
- R3: Once raised, bus_req_o stays high without a gap until the last word of the block has been written.
- R4: Before each word, the engine sits in a wait cycle until dev_rdy_i is sampled high, and it keeps bus_req_o asserted while waiting.
- R5: With direction 1 (memory to device), a word takes one cycle with mem_rd_o high at the current address. It is followed by one cycle with dev_wr_o high, where dev_wdata_o carries the mem_rdata_i value from the read cycle.
- R6: With direction 0 (device to memory), a word takes one cycle with dev_rd_o high. It is followed by one cycle with mem_wr_o high at the current address, where mem_wdata_o carries the dev_rdata_i value from the read cycle.
- R7: mem_addr_o starts at the loaded address and increases by one, modulo 2^ADDR_W, after each word.
- R8: Exactly the loaded number of words is moved. The count drops by one per word, and bus_req_o falls in the cycle after the write phase of the last word.
- R9: A start_i sampled in idle with a count of 0 never raises bus_req_o. It sets done_o and pulses done_pulse_o in the next cycle.
- R10: done_pulse_o is high for exactly one cycle at each completion. done_o stays high until the next start with a nonzero count.
- R11: cfg_we_i and start_i have no effect while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load address, count and direction (idle only) |
| cfg_addr_i | input | ADDR_W | Block start address |
| cfg_count_i | input | CNT_W | Number of words |
| cfg_dir_i | input | 1 | 1 = memory to device, 0 = device to memory |
| start_i | input | 1 | Begin transfer (idle only) |
| bus_req_o | output | 1 | Bus ownership request to the CPU |
| bus_ack_i | input | 1 | Bus grant from the CPU |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the read cycle |
| dev_rdy_i | input | 1 | Device ready for the next word |
| dev_rd_o | output | 1 | Device read strobe |
| dev_wr_o | output | 1 | Device write strobe |
| dev_wdata_o | output | DATA_W | Device write data |
| dev_rdata_i | input | DATA_W | Device read data, valid in the read cycle |
| done_o | output | 1 | Sticky completion flag |
| done_pulse_o | output | 1 | One-cycle completion pulse |

## Verification
The transfer is run in both directions with several grant patterns: a grant that arrives at once, a grant delayed by several cycles, and a grant that toggles at random. This separates waiting for the grant from waiting for the device. Device readiness is tried fully on and as random gaps, which shows that the bus is held between words. Block lengths of 0, 1, a few words and a long block across the top of the address space test the zero-count shortcut, the release on the last word and address wraparound. Configuration writes and starts are also thrown in during a transfer, and any change to the address or count stream shows that R11 is broken.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FETCH = 3'd3,
    ST_PUT   = 3'd4
  } dma_state_e;
endpackage

// File: rtl/dma_word_ctr.sv
module dma_word_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_i,
  output logic             zero_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] One = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= cnt_i;
    else if (dec_i)  cnt_q <= cnt_q - One;
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == One);

  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] Step = ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= addr_i;
    else if (inc_i)  addr_o <= addr_o + Step;
  end

  assert_step_by_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> (addr_o == $past(addr_o) + Step));
endmodule

// File: rtl/dma_data_latch.sv
module dma_data_latch #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              m2d_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] dev_rdata_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_o <= '0;
    else if (cap_i) data_o <= m2d_i ? mem_rdata_i : dev_rdata_i;
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_blk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cnt_zero_i,
  input  logic cnt_last_i,
  input  logic m2d_i,
  input  logic bus_ack_i,
  input  logic dev_rdy_i,
  output logic idle_o,
  output logic cap_o,
  output logic step_o,
  output logic bus_req_o,
  output logic mem_rd_o,
  output logic mem_wr_o,
  output logic dev_rd_o,
  output logic dev_wr_o,
  output logic done_o,
  output logic done_pulse_o
);
  dma_state_e state_q, state_d;
  logic       done_d, pulse_d;

  always_comb begin
    state_d = state_q;
    done_d  = done_o;
    pulse_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (cnt_zero_i) begin
          done_d  = 1'b1;
          pulse_d = 1'b1;
        end else begin
          done_d  = 1'b0;
          state_d = ST_REQ;
        end
      end
      ST_REQ:   if (bus_ack_i) state_d = ST_WAIT;
      ST_WAIT:  if (dev_rdy_i) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_PUT;
      ST_PUT: begin
        if (cnt_last_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          pulse_d = 1'b1;
        end else begin
          state_d = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      done_o       <= 1'b0;
      done_pulse_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      done_o       <= done_d;
      done_pulse_o <= pulse_d;
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign cap_o     = (state_q == ST_FETCH);
  assign step_o    = (state_q == ST_PUT);
  assign bus_req_o = !idle_o;
  assign mem_rd_o  = cap_o  &&  m2d_i;
  assign dev_rd_o  = cap_o  && !m2d_i;
  assign dev_wr_o  = step_o &&  m2d_i;
  assign mem_wr_o  = step_o && !m2d_i;

  // a fresh request never carries an access in its first cycle
  assert_grant_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> !(mem_rd_o || mem_wr_o || dev_rd_o || dev_wr_o));

  assert_wait_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_rd_o || dev_rd_o) |-> $past(dev_rdy_i));

  assert_one_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, dev_rd_o, dev_wr_o}));

  assert_read_then_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || dev_rd_o) |=> (mem_wr_o || dev_wr_o));

  assert_release_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> (done_pulse_o && done_o));

  assert_pulse_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse_o |=> !done_pulse_o);
endmodule

// File: rtl/dma_blk_ctrl.sv
module dma_blk_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic              cfg_dir_i,
  input  logic              start_i,
  output logic              bus_req_o,
  input  logic              bus_ack_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              dev_rdy_i,
  output logic              dev_rd_o,
  output logic              dev_wr_o,
  output logic [DATA_W-1:0] dev_wdata_o,
  input  logic [DATA_W-1:0] dev_rdata_i,
  output logic              done_o,
  output logic              done_pulse_o
);
  logic idle, cap, step, cnt_zero, cnt_last, m2d_q, load;
  logic [DATA_W-1:0] xfer_data;

  assign load = cfg_we_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   m2d_q <= 1'b0;
    else if (load) m2d_q <= cfg_dir_i;
  end

  dma_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .cnt_zero_i   (cnt_zero),
    .cnt_last_i   (cnt_last),
    .m2d_i        (m2d_q),
    .bus_ack_i    (bus_ack_i),
    .dev_rdy_i    (dev_rdy_i),
    .idle_o       (idle),
    .cap_o        (cap),
    .step_o       (step),
    .bus_req_o    (bus_req_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .dev_rd_o     (dev_rd_o),
    .dev_wr_o     (dev_wr_o),
    .done_o       (done_o),
    .done_pulse_o (done_pulse_o)
  );

  dma_word_ctr #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .cnt_i  (cfg_count_i),
    .dec_i  (step),
    .zero_o (cnt_zero),
    .last_o (cnt_last)
  );

  dma_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (cfg_addr_i),
    .inc_i  (step),
    .addr_o (mem_addr_o)
  );

  dma_data_latch #(.DATA_W(DATA_W)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .m2d_i       (m2d_q),
    .mem_rdata_i (mem_rdata_i),
    .dev_rdata_i (dev_rdata_i),
    .data_o      (xfer_data)
  );

  assign mem_wdata_o = xfer_data;
  assign dev_wdata_o = xfer_data;

  assert_cfg_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !step) |=> $stable(mem_addr_o));
endmodule

// File: tb/dma_blk_ctrl_tb.sv
module dma_blk_ctrl_tb;
  localparam int AW = 16, CW = 8, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_we = 0, cfg_dir = 0, start = 0, ack = 0, rdy = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic [DW-1:0] dev_rdata = '0;
  logic [DW-1:0] mem_rdata;
  logic bus_req, mem_rd, mem_wr, dev_rd, dev_wr, done, done_p;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, dev_wdata;

  assign mem_rdata = mem_addr ^ 16'hA5C3;

  dma_blk_ctrl #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_count_i(cfg_cnt), .cfg_dir_i(cfg_dir), .start_i(start),
    .bus_req_o(bus_req), .bus_ack_i(ack), .mem_addr_o(mem_addr),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .dev_rdy_i(rdy), .dev_rd_o(dev_rd),
    .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata),
    .done_o(done), .done_pulse_o(done_p));

  int n_chk = 0, n_fail = 0, cycles = 0;

  // behavioural reference: 0 idle, 1 requesting, 2 waiting device, 3 read, 4 write
  int m_st = 0, m_words = 0;
  logic [AW-1:0] m_addr = '0;
  int m_cnt = 0;
  logic m_dir = 0, m_done = 0, m_pulse = 0;
  logic [DW-1:0] m_data = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      m_pulse <= 1'b0;
      case (m_st)
        0: begin
          if (start) begin
            if (m_cnt == 0) begin m_done <= 1; m_pulse <= 1; end
            else begin m_done <= 0; m_st <= 1; end
          end
          if (cfg_we) begin m_addr <= cfg_addr; m_cnt <= cfg_cnt; m_dir <= cfg_dir; end
        end
        1: if (ack) m_st <= 2;
        2: if (rdy) m_st <= 3;
        3: begin m_data <= m_dir ? (m_addr ^ 16'hA5C3) : dev_rdata; m_st <= 4; end
        default: begin
          m_addr <= m_addr + 1'b1;
          m_cnt <= m_cnt - 1;
          m_words <= m_words + 1;
          if (m_cnt == 1) begin m_st <= 0; m_done <= 1; m_pulse <= 1; end
          else m_st <= 2;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2,R3,R4 bus_req", bus_req, m_st != 0);
      chk("R5 mem_rd", mem_rd, m_st == 3 && m_dir);
      chk("R5 dev_wr", dev_wr, m_st == 4 && m_dir);
      chk("R6 dev_rd", dev_rd, m_st == 3 && !m_dir);
      chk("R6 mem_wr", mem_wr, m_st == 4 && !m_dir);
      chk("R7,R11 addr", mem_addr, m_addr);
      if (m_st == 4 && m_dir)  chk("R5 dev_wdata", dev_wdata, m_data);
      if (m_st == 4 && !m_dir) chk("R6 mem_wdata", mem_wdata, m_data);
      chk("R10 done", done, m_done);
      chk("R9,R10 pulse", done_p, m_pulse);
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // ack_mode: 0 immediate, 1 delayed by 5, 2 random; rdy_mode: 0 always, 1 random
  task automatic run(input logic [AW-1:0] a, input int n, input logic d,
                     input int ack_mode, input int rdy_mode, input bit noise);
    int wait_n;
    int words0;
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_cnt = CW'(n); cfg_dir = d;
    @(negedge clk);
    cfg_we = 0; start = 1;
    words0 = m_words;
    @(negedge clk);
    start = 0;
    wait_n = 0;
    while (m_st != 0 && wait_n < 5000) begin
      case (ack_mode)
        0: ack = 1;
        1: ack = (wait_n >= 5);
        default: ack = ($urandom % 3) == 0;
      endcase
      rdy = (rdy_mode == 0) ? 1'b1 : (($urandom % 2) == 0);
      dev_rdata = DW'($urandom);
      if (noise) begin
        cfg_we = ($urandom % 4) == 0; start = ($urandom % 4) == 0;
        cfg_addr = AW'($urandom); cfg_cnt = CW'($urandom); cfg_dir = $urandom;
      end
      wait_n++;
      @(negedge clk);
    end
    cfg_we = 0; start = 0; ack = 0; rdy = 0;
    // R8: exact word count moved per block
    chk("R8 words", m_words - words0, n);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bus_req", bus_req, 0);
    chk("R1 strobes", {mem_rd, mem_wr, dev_rd, dev_wr}, 0);
    chk("R1 done", {done, done_p}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {bus_req, done, done_p}, 0);

    run(16'h0100, 0, 1, 0, 0, 0);   // R9 zero count
    chk("R9 no request", bus_req, 0);
    run(16'h0010, 4, 1, 0, 0, 0);
    run(16'h0200, 1, 0, 1, 0, 0);
    run(16'hFFFE, 5, 0, 2, 1, 0);   // wraps
    run(16'h1234, 6, 1, 1, 1, 1);   // R11 noise while busy
    run(16'h4000, 0, 0, 0, 0, 0);   // zero after done already set
    run(16'hFF80, 255, 1, 2, 1, 1);
    for (int i = 0; i < 10; i++)
      run(AW'($urandom), 1 + ($urandom % 12), $urandom, $urandom % 3, $urandom % 2, 1);
    finish_run();
  end
endmodule